// File: doc/BRIEF.md
# Access Violation Error Capture Unit

This block sits behind a region checker and records what went wrong when an access is refused. Each slave port has its own input channel. When a refusal report comes in on a port whose error flag is clear, the block stores the details and raises that port's flag: the faulting address, the number of the issuing master, whether the access was a read or a write, a two-bit attribute code, and a hit code. The hit code says whether no region matched, whether one region matched and refused, or whether several overlapping regions matched and refused.

The record then stays fixed, so the first fault on a port survives any later ones, until software clears the flag. Software reads the flags and the records through a small word-addressed register interface with combinational read data. It clears flags by writing ones to the flag word. A refusal that arrives in the same cycle as its port's clear wins: it is captured and the flag stays set.

Top module: `av_err_capture`

## Requirements
- R1: After a synchronous reset, every error flag is 0 and every mapped register reads 0.
- R2: A report on port p whose flag is clear sets flag p at the next clock edge and loads port p's record from that report.
- R3: While flag p is set and no clear hits it, later reports on port p leave the record and the flag unchanged.
- R4: A write of the mask to word 0 clears exactly the flags whose mask bit is 1. Flags whose mask bit is 0 are untouched, and a clear leaves the stored record readable.
- R5: When a report on port p and a clear of flag p arrive in the same cycle, the report is captured and flag p stays 1.
- R6: Ports are independent. Reports on several ports in one cycle are all captured, each in its own record.
- R7: The detail word holds the master number in bits 3:0 and the direction in bit 8 (0 = read, 1 = write). It holds the attribute in bits 10:9 (0 user instruction, 1 user data, 2 supervisor instruction, 3 supervisor data) and the hit code in bits 13:12 (0 no region, 1 one region, 2 overlapping regions). All other bits read 0.
- R8: The register map is: word 0 holds the flags in bits 4:0; word 1+2p holds port p's address; word 2+2p holds port p's detail word. Unmapped words read 0, and writes to any word other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 5 | Per-port refusal report strobe |
| viol_addr | input | 160 | Per-port faulting address, port p in bits 32p+31:32p |
| viol_master | input | 20 | Per-port master number, port p in bits 4p+3:4p |
| viol_write | input | 5 | Per-port direction, 1 = write |
| viol_attr | input | 10 | Per-port attribute code, port p in bits 2p+1:2p |
| viol_hit | input | 10 | Per-port hit code, port p in bits 2p+1:2p |
| reg_addr | input | 4 | Register word address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wmask | input | 5 | Write data for the flag word, one clear bit per port |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| err_flags | output | 5 | Per-port sticky error flags |

## Verification
The bench goes after the second report on a port that is already flagged. A design that loads on every report would overwrite the first fault's address and detail. It also tests a clear that coincides with a new report. A design that lets the clear win would drop that fault and leave the flag low. Clears with partial masks and stray writes to record words check that a clear cannot touch a neighbour's flag and that a write off word 0 cannot clear anything. Detail words built from distinct field values expose any bit that lands in the wrong position.

// File: rtl/av_cap_pkg.sv
package av_cap_pkg;

    parameter int ADDR_W       = 32;
    parameter int MASTER_W     = 4;
    parameter int DATA_W       = 32;
    parameter int DET_DIR_BIT  = 8;
    parameter int DET_ATTR_LSB = 9;
    parameter int DET_HIT_LSB  = 12;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } xfer_dir_e;

    typedef enum logic [1:0] {
        ATTR_USER_INSN = 2'd0,
        ATTR_USER_DATA = 2'd1,
        ATTR_SUPV_INSN = 2'd2,
        ATTR_SUPV_DATA = 2'd3
    } acc_attr_e;

    typedef enum logic [1:0] {
        HIT_NONE    = 2'd0,
        HIT_ONE     = 2'd1,
        HIT_OVERLAP = 2'd2,
        HIT_RSVD    = 2'd3
    } hit_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   addr;
        logic [MASTER_W-1:0] master;
        xfer_dir_e           dir;
        acc_attr_e           attr;
        hit_kind_e           hit;
    } viol_rec_t;

    function automatic logic [DATA_W-1:0] pack_detail(viol_rec_t r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MASTER_W-1:0]                  = r.master;
        w[DET_DIR_BIT]                   = r.dir;
        w[DET_ATTR_LSB+1:DET_ATTR_LSB]   = r.attr;
        w[DET_HIT_LSB+1:DET_HIT_LSB]     = r.hit;
        return w;
    endfunction

endpackage

// File: rtl/av_cap_slot.sv
module av_cap_slot
    import av_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rpt_valid,
    input  viol_rec_t rpt,
    input  logic      clr,
    output logic      flag_o,
    output viol_rec_t rec_o
);

    logic      flag_q;
    viol_rec_t rec_q;
    logic      load;

    // capture is armed while the flag is low, or re-armed by a clear this cycle
    assign load = rpt_valid && (!flag_q || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            rec_q  <= '0;
        end else if (load) begin
            flag_q <= 1'b1;
            rec_q  <= rpt;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign rec_o  = rec_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!flag_o && rec_o == '0));

    assert_first_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && !flag_o) |=> (flag_o && rec_o == $past(rpt)));

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr) |=> (flag_o && $stable(rec_o)));

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (clr && !rpt_valid) |=> (!flag_o && $stable(rec_o)));

    assert_report_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && rpt_valid) |=> (flag_o && rec_o == $past(rpt)));

endmodule

// File: rtl/av_cap_regs.sv
module av_cap_regs
    import av_cap_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int REG_AW    = 4
) (
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic                           reg_wr_en,
    input  logic [NUM_PORTS-1:0]           reg_wmask,
    input  logic [NUM_PORTS-1:0]           flags,
    input  viol_rec_t [NUM_PORTS-1:0]      recs,
    output logic [NUM_PORTS-1:0]           clr_o,
    output logic [DATA_W-1:0]              reg_rdata
);

    localparam logic [REG_AW-1:0] FLAG_WORD = '0;

    assign clr_o = (reg_wr_en && reg_addr == FLAG_WORD) ? reg_wmask : '0;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == FLAG_WORD)
            reg_rdata = DATA_W'(flags);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == REG_AW'(1 + 2*p))
                reg_rdata = DATA_W'(recs[p].addr);
            if (reg_addr == REG_AW'(2 + 2*p))
                reg_rdata = pack_detail(recs[p]);
        end
    end

endmodule

// File: rtl/av_err_capture.sv
module av_err_capture
    import av_cap_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int REG_AW    = $clog2(2*NUM_PORTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          viol_valid,
    input  logic [NUM_PORTS*ADDR_W-1:0]   viol_addr,
    input  logic [NUM_PORTS*MASTER_W-1:0] viol_master,
    input  logic [NUM_PORTS-1:0]          viol_write,
    input  logic [NUM_PORTS*2-1:0]        viol_attr,
    input  logic [NUM_PORTS*2-1:0]        viol_hit,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic                          reg_wr_en,
    input  logic [NUM_PORTS-1:0]          reg_wmask,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [NUM_PORTS-1:0]          err_flags
);

    logic [NUM_PORTS-1:0]      clr;
    logic [NUM_PORTS-1:0]      flags;
    viol_rec_t [NUM_PORTS-1:0] recs;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        viol_rec_t rpt;
        assign rpt = '{
            addr:   viol_addr[p*ADDR_W +: ADDR_W],
            master: viol_master[p*MASTER_W +: MASTER_W],
            dir:    xfer_dir_e'(viol_write[p]),
            attr:   acc_attr_e'(viol_attr[2*p +: 2]),
            hit:    hit_kind_e'(viol_hit[2*p +: 2])
        };

        av_cap_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .rpt_valid (viol_valid[p]),
            .rpt       (rpt),
            .clr       (clr[p]),
            .flag_o    (flags[p]),
            .rec_o     (recs[p])
        );
    end

    av_cap_regs #(
        .NUM_PORTS (NUM_PORTS),
        .REG_AW    (REG_AW)
    ) u_regs (
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wmask (reg_wmask),
        .flags     (flags),
        .recs      (recs),
        .clr_o     (clr),
        .reg_rdata (reg_rdata)
    );

    assign err_flags = flags;

    assert_stray_write_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr != '0 && viol_valid == '0) |=> $stable(err_flags));

    assert_flags_only_rise_on_report_R6: assert property (@(posedge clk) disable iff (rst)
        (viol_valid == '0) |=> ((err_flags & ~$past(err_flags)) == '0));

endmodule

// File: tb/tb_av_err_capture.sv
module tb_av_err_capture;

    localparam int CLK_P = 10;
    localparam int NP    = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0]    viol_valid;
    logic [NP*32-1:0] viol_addr;
    logic [NP*4-1:0]  viol_master;
    logic [NP-1:0]    viol_write;
    logic [NP*2-1:0]  viol_attr;
    logic [NP*2-1:0]  viol_hit;
    logic [3:0]       reg_addr;
    logic             reg_wr_en;
    logic [NP-1:0]    reg_wmask;
    logic [31:0]      reg_rdata;
    logic [NP-1:0]    err_flags;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    bit          m_flag [NP];
    logic [31:0] m_addr [NP];
    logic [31:0] m_det  [NP];

    always #(CLK_P/2) clk = ~clk;

    av_err_capture dut (
        .clk(clk), .rst(rst), .viol_valid(viol_valid), .viol_addr(viol_addr),
        .viol_master(viol_master), .viol_write(viol_write), .viol_attr(viol_attr),
        .viol_hit(viol_hit), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .err_flags(err_flags)
    );

    function automatic logic [31:0] det(int m, int w, int a, int h);
        return 32'(m) | (32'(w) << 8) | (32'(a) << 9) | (32'(h) << 12);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [3:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 0) for (int p = 0; p < NP; p++) r[p] = m_flag[p];
        for (int p = 0; p < NP; p++) begin
            if (a == 4'(1 + 2*p)) r = m_addr[p];
            if (a == 4'(2 + 2*p)) r = m_det[p];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                m_flag[p] = 0; m_addr[p] = '0; m_det[p] = '0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit c;
                c = reg_wr_en && reg_addr == 0 && reg_wmask[p];
                if (viol_valid[p] && (!m_flag[p] || c)) begin
                    m_flag[p] = 1;
                    m_addr[p] = viol_addr[p*32 +: 32];
                    m_det[p]  = det(int'(viol_master[p*4 +: 4]), int'(viol_write[p]),
                                    int'(viol_attr[2*p +: 2]), int'(viol_hit[2*p +: 2]));
                end else if (c) begin
                    m_flag[p] = 0;
                end
            end
        end
        #(CLK_P/4);
        begin
            logic [31:0] ef;
            ef = '0;
            for (int p = 0; p < NP; p++) ef[p] = m_flag[p];
            chk("R2 model flags", 32'(err_flags), ef);
            chk("R8 model rdata", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic idle();
        viol_valid = '0; viol_addr = '0; viol_master = '0; viol_write = '0;
        viol_attr = '0; viol_hit = '0; reg_wr_en = 0; reg_wmask = '0;
    endtask

    task automatic tick();
        @(posedge clk); #(CLK_P/4 + 1);
    endtask

    task automatic put(int p, logic [31:0] a, int m, int w, int at, int h);
        viol_valid[p] = 1'b1;
        viol_addr[p*32 +: 32] = a;
        viol_master[p*4 +: 4] = 4'(m);
        viol_write[p] = 1'(w);
        viol_attr[2*p +: 2] = 2'(at);
        viol_hit[2*p +: 2] = 2'(h);
    endtask

    task automatic rd(int a, string req, logic [31:0] exp);
        @(negedge clk); idle(); reg_addr = 4'(a);
        tick();
        chk(req, reg_rdata, exp);
    endtask

    task automatic clear(logic [NP-1:0] m);
        @(negedge clk); idle(); reg_addr = 0; reg_wr_en = 1; reg_wmask = m;
        tick();
    endtask

    initial begin
        #(CLK_P*20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; reg_addr = 0; idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        tick();
        // R1 reset state
        chk("R1 flags", 32'(err_flags), 0);
        for (int a = 0; a < 11; a++) rd(a, "R1 reg", 0);

        // R2 first capture, R7 field positions
        @(negedge clk); idle(); reg_addr = 5;
        put(2, 32'h1000_0040, 3, 1, 3, 1);
        tick();
        chk("R2 flag", 32'(err_flags), 32'h04);
        chk("R2 addr", reg_rdata, 32'h1000_0040);
        rd(6, "R7 detail", 32'h0000_1703);

        // R3 later report ignored
        @(negedge clk); idle(); reg_addr = 5;
        put(2, 32'hDEAD_BEE0, 9, 0, 0, 2);
        tick();
        chk("R3 addr held", reg_rdata, 32'h1000_0040);
        rd(6, "R3 detail held", 32'h0000_1703);
        chk("R3 flag", 32'(err_flags), 32'h04);

        // R4 partial masks
        clear(5'b11011);
        chk("R4 other mask bits", 32'(err_flags), 32'h04);
        clear(5'b00100);
        chk("R4 cleared", 32'(err_flags), 0);
        rd(5, "R4 record kept", 32'h1000_0040);

        // R5 clear and report together
        @(negedge clk); idle(); put(2, 32'h2000_0000, 1, 0, 1, 0);
        tick();
        @(negedge clk); idle(); reg_addr = 0; reg_wr_en = 1; reg_wmask = 5'b00100;
        put(2, 32'h3000_0020, 7, 1, 2, 2);
        tick();
        chk("R5 flag stays", 32'(err_flags), 32'h04);
        rd(5, "R5 new addr", 32'h3000_0020);
        rd(6, "R5 new detail", det(7, 1, 2, 2));

        // R6 simultaneous ports
        @(negedge clk); idle();
        put(0, 32'hA000_0000, 2, 0, 1, 1);
        put(4, 32'hB000_01E0, 5, 1, 0, 0);
        tick();
        chk("R6 flags", 32'(err_flags), 32'h15);
        rd(1, "R6 port0 addr", 32'hA000_0000);
        rd(9, "R6 port4 addr", 32'hB000_01E0);
        rd(10, "R6 port4 detail", det(5, 1, 0, 0));
        rd(2, "R6 port0 detail", det(2, 0, 1, 1));

        // R7 encodings on other ports
        @(negedge clk); idle();
        put(1, 32'h0000_0100, 6, 0, 0, 0);
        put(3, 32'hFFFF_FFE0, 15, 0, 2, 2);
        tick();
        rd(4, "R7 read/user insn/no hit", det(6, 0, 0, 0));
        rd(8, "R7 supv insn overlap", 32'h0000_240F);
        rd(0, "R8 flag word", 32'h1F);

        // R8 stray writes and unmapped words
        @(negedge clk); idle(); reg_addr = 5; reg_wr_en = 1; reg_wmask = '1;
        tick();
        chk("R8 stray write flags", 32'(err_flags), 32'h1F);
        rd(5, "R8 stray write addr", 32'h3000_0020);
        for (int a = 11; a < 16; a++) rd(a, "R8 unmapped", 0);

        clear('1);
        chk("R4 clear all", 32'(err_flags), 0);
        repeat (2) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule